// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block sits on the system clock and runs a 16-bit-word serial EEPROM over a select line, a serial clock, a data line to the memory and a data line back. A client hands it one command at a time through a valid/ready handshake. The four commands are: read a burst of words, write one word, arm programming and disarm programming. The controller builds the frame. It derives the serial clock by dividing the system clock and shifts the frame out. For a read it drops the leading dummy bit and returns each 16-bit word with a one-cycle strobe.

Between two frames the select line is held low for a minimum number of system cycles. After a write the controller starts the internal programming cycle by lowering the select line. It then raises the select line again with the serial clock idle and watches the returned data line until the memory reports ready. If the memory stays busy past a cycle limit, the controller ends the command with an error flag.

Top module: `ser_eeprom_host`

## Requirements
- R1: After reset `cs_o` and `sk_o` are low and `req_ready_o` is high. `req_ready_o` is high only while the controller is idle, and `cs_o` is then low. A request is taken in the cycle where `req_valid_i` and `req_ready_o` are both high, and `req_ready_o` is low in the next cycle.
- R2: Command codes on `req_cmd_i` are 0 read, 1 write, 2 arm, 3 disarm. Every frame opens with these bits on `di_o`, sampled at rising `sk_o`: a 1, then a 2-bit opcode (read 10, write 01, arm and disarm 00), then ADDR_W address bits with the MSB first.
- R3: Arm puts 11 in the two top address bits and disarm puts 00 there. All lower address bits are 0. Each of these frames is exactly 3+ADDR_W clock rises long. A write sent while disarmed leaves memory unchanged.
- R4: `sk_o` changes only on a divider event. Inside a frame it is high for SK_HALF cycles, and successive rises are 2*SK_HALF cycles apart. `sk_o` is low whenever `cs_o` is low.
- R5: On a read, the bit sampled on the first rise after the address is dropped. Each later group of 16 bits, sampled on rising `sk_o` with the MSB first, comes out on `rd_data_o` with a single-cycle `rd_valid_o`, and only while `cs_o` is high.
- R6: A read of `req_len_i`+1 words uses one select window of exactly 3+ADDR_W+1+16*(`req_len_i`+1) rises. The words follow consecutive addresses and wrap from the top address to 0.
- R7: A write frame is the header followed by the 16 bits of `req_wdata_i` with the MSB first, 3+ADDR_W+16 rises in total. `cs_o` drops on the edge that ends the last bit.
- R8: Once `cs_o` falls, it stays low for at least CS_GAP cycles before it rises again. This holds between frames and also before the status poll.
- R9: After a write, `cs_o` rises again with `sk_o` held low. When `do_i` is sampled high, `done_o` pulses for one cycle with `err_o` low, and `cs_o` drops. `done_o` never lasts two cycles.
- R10: If `do_i` stays low for the whole poll, which lasts at least TMO_CYC cycles, `done_o` and `err_o` pulse together, `cs_o` drops and the controller returns to idle. If `do_i` is high in the last cycle of the poll, the write counts as a success.
- R11: Read, arm and disarm commands pulse `done_o` with `err_o` low in the cycle where `cs_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| req_cmd_i | input | 2 | 0 read, 1 write, 2 arm, 3 disarm |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | 16 | Word to write |
| req_len_i | input | LEN_W | Read burst length minus one |
| rd_data_o | output | 16 | Word read back |
| rd_valid_o | output | 1 | One-cycle strobe for `rd_data_o` |
| done_o | output | 1 | One-cycle end-of-command pulse |
| err_o | output | 1 | Programming timeout, comes with `done_o` |
| cs_o | output | 1 | Memory select |
| sk_o | output | 1 | Serial clock |
| di_o | output | 1 | Serial data to the memory |
| do_i | input | 1 | Serial data and status from the memory |

## Verification
Two events can land in the same cycle here: the memory turning ready and the poll running out of time. When they collide, the poll must end as a success. The bench provokes the collision by sweeping the model's programming time, one cycle per step, across the poll limit, so that the ready edge falls before the last polled cycle, on it, and after it. Each write is judged on its own: a monitor records whether `do_i` was ever seen high while the poll window was open. The controller's `err_o` must be exactly the opposite of that record. A timeout must also come only after a window of at least TMO_CYC cycles.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_WR  = 2'd1,
    CMD_EN  = 2'd2,
    CMD_DIS = 2'd3
  } eep_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SHIFT,
    S_WGAP,
    S_POLL,
    S_GAP
  } eep_st_e;

  // two opcode bits that follow the start bit
  function automatic logic [1:0] op_bits(eep_cmd_e c);
    case (c)
      CMD_RD:  return 2'b10;
      CMD_WR:  return 2'b01;
      default: return 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/eep_sk_tick.sv
module eep_sk_tick #(
  parameter int HALF = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (HALF <= 1) begin : g_every
      assign tick_o = run_i;
    end else begin : g_div
      localparam int CW = $clog2(HALF);
      logic [CW-1:0] cnt_q;
      logic          at_end;
      assign at_end = (cnt_q == CW'(HALF - 1));
      assign tick_o = run_i && at_end;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run_i || at_end) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
      end

      // R4
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/eep_dcnt.sv
module eep_dcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;
  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (dec_i && !zero_o) cnt_q <= cnt_q - 1'b1;
  end

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/ser_eeprom_host.sv
module ser_eeprom_host
  import eep_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int LEN_W   = 4,
  parameter int SK_HALF = 100,
  parameter int CS_GAP  = 50,
  parameter int TMO_CYC = 2000000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [1:0]          req_cmd_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [WORD_W-1:0]   req_wdata_i,
  input  logic [LEN_W-1:0]    req_len_i,
  output logic [WORD_W-1:0]   rd_data_o,
  output logic                rd_valid_o,
  output logic                done_o,
  output logic                err_o,
  output logic                cs_o,
  output logic                sk_o,
  output logic                di_o,
  input  logic                do_i
);
  localparam int HDR_W     = 3 + ADDR_W;
  localparam int TX_W      = HDR_W + WORD_W;
  localparam int MAX_SLOTS = HDR_W + 1 + WORD_W * (2 ** LEN_W);
  localparam int IW        = $clog2(MAX_SLOTS + 1);
  localparam int GW        = $clog2(CS_GAP + 1) + 1;
  localparam int TW        = $clog2(TMO_CYC + 1) + 1;

  function automatic logic [HDR_W-1:0] frame_hdr(eep_cmd_e c, logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] f;
    f = '0;
    case (c)
      CMD_RD, CMD_WR: f = a;
      CMD_EN:         f[ADDR_W-1 -: 2] = 2'b11;
      default:        f = '0;
    endcase
    return {1'b1, op_bits(c), f};
  endfunction

  function automatic logic [IW-1:0] slot_count(eep_cmd_e c, logic [LEN_W-1:0] n);
    int s;
    case (c)
      CMD_RD:  s = HDR_W + 1 + WORD_W * (int'(n) + 1);
      CMD_WR:  s = HDR_W + WORD_W;
      default: s = HDR_W;
    endcase
    return IW'(s);
  endfunction

  // true on the slot carrying the last bit of a data word
  function automatic logic is_word_end(logic [IW-1:0] i);
    int d;
    d = int'(i) - (HDR_W + 1);
    return (d >= 0) && ((d & (WORD_W - 1)) == (WORD_W - 1));
  endfunction

  eep_st_e          st_q;
  eep_cmd_e         cmd_q, cmd_in;
  logic [IW-1:0]    idx_q, last_q;
  logic [TX_W-1:0]  tx_q;
  logic [WORD_W-1:0] rx_q;
  logic [HDR_W-1:0] hdr_in;

  // named internal events
  logic sk_tick, ev_rise, ev_fall, ev_last, word_end, accept;
  logic gap_zero, tmo_zero, gap_load, gap_dec, tmo_load, tmo_dec;

  assign cmd_in      = eep_cmd_e'(req_cmd_i);
  assign hdr_in      = frame_hdr(cmd_in, req_addr_i);
  assign req_ready_o = (st_q == S_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign ev_rise     = sk_tick && !sk_o;
  assign ev_fall     = sk_tick && sk_o;
  assign ev_last     = ev_fall && (idx_q == last_q);
  assign word_end    = ev_rise && (cmd_q == CMD_RD) && is_word_end(idx_q);
  assign gap_load    = ev_last || ((st_q == S_POLL) && (do_i || tmo_zero));
  assign gap_dec     = (st_q == S_GAP) || (st_q == S_WGAP);
  assign tmo_load    = (st_q == S_WGAP) && gap_zero;
  assign tmo_dec     = (st_q == S_POLL);

  eep_sk_tick #(.HALF(SK_HALF)) i_tick (
    .clk(clk), .rst_n(rst_n), .run_i(st_q == S_SHIFT), .tick_o(sk_tick)
  );

  eep_dcnt #(.W(GW)) i_gap (
    .clk(clk), .rst_n(rst_n), .load_i(gap_load), .val_i(GW'(CS_GAP)),
    .dec_i(gap_dec), .zero_o(gap_zero)
  );

  eep_dcnt #(.W(TW)) i_tmo (
    .clk(clk), .rst_n(rst_n), .load_i(tmo_load), .val_i(TW'(TMO_CYC)),
    .dec_i(tmo_dec), .zero_o(tmo_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      cmd_q      <= CMD_RD;
      idx_q      <= '0;
      last_q     <= '0;
      tx_q       <= '0;
      rx_q       <= '0;
      cs_o       <= 1'b0;
      sk_o       <= 1'b0;
      di_o       <= 1'b0;
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      rd_valid_o <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      case (st_q)
        S_IDLE: if (accept) begin
          cmd_q  <= cmd_in;
          idx_q  <= '0;
          last_q <= slot_count(cmd_in, req_len_i) - 1'b1;
          tx_q   <= {hdr_in, (cmd_in == CMD_WR) ? req_wdata_i : '0};
          di_o   <= hdr_in[HDR_W-1];
          cs_o   <= 1'b1;
          sk_o   <= 1'b0;
          st_q   <= S_SHIFT;
        end
        S_SHIFT: begin
          if (ev_rise) begin
            sk_o <= 1'b1;
            rx_q <= {rx_q[WORD_W-2:0], do_i};
            if (word_end) begin
              rd_data_o  <= {rx_q[WORD_W-2:0], do_i};
              rd_valid_o <= 1'b1;
            end
          end
          if (ev_fall) begin
            sk_o <= 1'b0;
            if (ev_last) begin
              cs_o <= 1'b0;
              di_o <= 1'b0;
              if (cmd_q == CMD_WR) st_q <= S_WGAP;
              else begin
                st_q   <= S_GAP;
                done_o <= 1'b1;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
              di_o  <= tx_q[TX_W-2];
              tx_q  <= tx_q << 1;
            end
          end
        end
        S_WGAP: if (gap_zero) begin
          cs_o <= 1'b1;
          st_q <= S_POLL;
        end
        S_POLL: if (do_i || tmo_zero) begin
          cs_o   <= 1'b0;
          done_o <= 1'b1;
          err_o  <= !do_i;
          st_q   <= S_GAP;
        end
        S_GAP: if (gap_zero) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // checker state: cycles the select line has been low, saturating
  localparam int LW = $clog2(CS_GAP + 1) + 1;
  logic [LW-1:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       low_run_q <= LW'(CS_GAP);
    else if (cs_o)                    low_run_q <= '0;
    else if (low_run_q < LW'(CS_GAP)) low_run_q <= low_run_q + 1'b1;
  end

  // R8
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_o) |-> (low_run_q >= LW'(CS_GAP)));
  // R4
  sk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_o |-> !sk_o);
  // R4
  sk_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sk_tick |=> $stable(sk_o));
  // R1
  ready_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> !cs_o);
  // R5
  rd_valid_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> cs_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);
  // R9
  poll_sk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_POLL) |-> !sk_o);
endmodule

// File: tb/test_ser_eeprom_host.sv
module test_ser_eeprom_host;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW   = 6;
  localparam int LW   = 4;
  localparam int HALF = 2;
  localparam int GAP  = 3;
  localparam int TMO  = 40;
  localparam int HDR  = 3 + AW;
  localparam int NW   = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid_i = 1'b0;
  logic req_ready_o;
  logic [1:0] req_cmd_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [LW-1:0] req_len_i = '0;
  logic [15:0] rd_data_o;
  logic rd_valid_o, done_o, err_o, cs_o, sk_o, di_o;
  logic do_w;

  always #2.5 clk = ~clk;

  ser_eeprom_host #(.ADDR_W(AW), .LEN_W(LW), .SK_HALF(HALF), .CS_GAP(GAP), .TMO_CYC(TMO))
  i_ser_eeprom_host (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_cmd_i(req_cmd_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .req_len_i(req_len_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .done_o(done_o), .err_o(err_o), .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o), .do_i(do_w)
  );

  function automatic logic [15:0] seed(int i);
    return 16'((i * 16'h3B1D) ^ 16'hC35A);
  endfunction

  // ---------------- memory model ----------------
  logic [15:0] mem [NW];
  logic [15:0] exp_mem [NW];
  int  busy_len = 10;
  time busy_until = 0;
  logic busy = 1'b0;
  logic m_start = 0, m_rd = 0, m_wr = 0, m_en = 0, m_stat = 0, m_do = 0;
  int  m_n = 0, m_bit = 0, m_wcnt = 0;
  logic [AW+1:0] m_hdr = '0;
  logic [AW-1:0] m_addr = '0;
  logic [15:0] m_wdat = '0;

  initial for (int i = 0; i < NW; i++) begin mem[i] = seed(i); exp_mem[i] = seed(i); end

  always @(posedge clk) busy <= ($time < busy_until);
  assign do_w = cs_o && (m_rd ? m_do : (m_stat && !busy));

  always @(posedge sk_o or negedge cs_o) begin
    if (!cs_o) begin
      if (m_wr && m_wcnt == 16 && m_en) begin
        mem[m_addr] = m_wdat;
        busy_until = $time + busy_len * 5;
      end
      m_stat = m_wr && m_wcnt == 16;
      m_start = 0; m_rd = 0; m_wr = 0; m_n = 0;
    end else if (!m_start) begin
      if (di_o) begin m_start = 1; m_stat = 0; m_n = 0; end
    end else if (m_n < AW + 2) begin
      m_hdr = {m_hdr[AW:0], di_o};
      m_n++;
      if (m_n == AW + 2) begin
        m_addr = m_hdr[AW-1:0];
        case (m_hdr[AW+1:AW])
          2'b10: begin m_rd = 1; m_bit = 0; m_do <= 1'b0; end
          2'b01: begin m_wr = 1; m_wcnt = 0; end
          default: begin
            if (m_hdr[AW-1:AW-2] == 2'b11) m_en = 1;
            else if (m_hdr[AW-1:AW-2] == 2'b00) m_en = 0;
          end
        endcase
      end
    end else if (m_rd) begin
      m_do <= mem[m_addr][15 - m_bit];
      m_bit++;
      if (m_bit == 16) begin m_bit = 0; m_addr = m_addr + 1'b1; end
    end else if (m_wr && m_wcnt < 16) begin
      m_wdat = {m_wdat[14:0], di_o};
      m_wcnt++;
    end
  end

  // ---------------- bench bookkeeping ----------------
  int checks = 0, errors = 0;
  int cyc = 0;
  logic finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  // ---------------- pin monitor (negedge sampling) ----------------
  logic [299:0] fsh = '0, lat_sh = '0;
  int fcnt = 0, lat_n = 0;
  logic sk_p = 0, cs_p = 0, pw = 0, rdy_seen = 0;
  int poll_len = 0, last_rise = 0, mcyc = 0, low_cnt = 1000;
  logic rise_ok = 0;
  int sk_bad = 0, gap_bad = 0, rise_meas = 0;

  always @(negedge clk) begin
    mcyc++;
    if (sk_o && !sk_p) begin
      fsh = {fsh[298:0], di_o};
      fcnt++;
      if (rise_ok) begin
        rise_meas++;
        if (mcyc - last_rise != 2 * HALF) sk_bad++;
      end
      last_rise = mcyc;
      rise_ok = 1;
    end
    if (!sk_o && sk_p && (mcyc - last_rise != HALF)) sk_bad++;
    if (cs_o && !cs_p) begin
      if (low_cnt < GAP) gap_bad++;
      low_cnt = 0;
      fcnt = 0;
    end
    if (!cs_o && cs_p) begin
      if (fcnt > 0) begin lat_sh = fsh; lat_n = fcnt; pw = (fcnt == HDR + 16); end
      else pw = 0;
    end
    if (!cs_o) begin low_cnt++; rise_ok = 0; end
    if (cs_o && pw) begin
      poll_len++;
      if (do_w) rdy_seen = 1;
    end
    sk_p = sk_o; cs_p = cs_o;
  end

  // ---------------- request driver ----------------
  logic [15:0] words [16];
  int nwords = 0;
  logic got_err = 0;

  task automatic run_req(input int cmd, input int addr, input int wdata, input int len);
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    rdy_seen = 0; poll_len = 0; nwords = 0;
    req_valid_i = 1; req_cmd_i = 2'(cmd); req_addr_i = AW'(addr);
    req_wdata_i = 16'(wdata); req_len_i = LW'(len);
    @(negedge clk);
    req_valid_i = 0;
    chk(!req_ready_o, "R1 ready drops after accept", 32'(req_ready_o), 0);
    while (!done_o) begin
      if (rd_valid_o && nwords < 16) begin words[nwords] = rd_data_o; nwords++; end
      @(negedge clk);
    end
    got_err = err_o;
    @(negedge clk);
  endtask

  function automatic logic [HDR-1:0] exp_hdr(int cmd, int addr);
    case (cmd)
      0: return {1'b1, 2'b10, AW'(addr)};
      1: return {1'b1, 2'b01, AW'(addr)};
      2: return {1'b1, 2'b00, 2'b11, (AW-2)'(0)};
      default: return {1'b1, 2'b00, AW'(0)};
    endcase
  endfunction

  function automatic logic [HDR-1:0] got_hdr();
    return HDR'(lat_sh >> (lat_n - HDR));
  endfunction

  task automatic do_write(input int addr, input int data);
    run_req(1, addr, data, 0);
    chk(lat_n == HDR + 16, "R7 write frame length", 32'(lat_n), 32'(HDR + 16));
    chk(got_hdr() == exp_hdr(1, addr), "R2 write header", 32'(got_hdr()), 32'(exp_hdr(1, addr)));
    chk(lat_sh[15:0] == 16'(data), "R7 write data bits", 32'(lat_sh[15:0]), 32'(data));
    chk(got_err == !rdy_seen, "R10 err versus ready seen in poll", 32'(got_err), 32'(!rdy_seen));
    if (got_err) chk(poll_len >= TMO, "R10 poll window length", 32'(poll_len), 32'(TMO));
    if (m_en) exp_mem[addr] = 16'(data);
    while (busy) @(negedge clk);
  endtask

  task automatic do_read(input int addr, input int len);
    run_req(0, addr, 0, len);
    chk(got_err == 0, "R11 read done without err", 32'(got_err), 0);
    chk(lat_n == HDR + 1 + 16 * (len + 1), "R6 read frame length", 32'(lat_n), 32'(HDR + 1 + 16 * (len + 1)));
    chk(got_hdr() == exp_hdr(0, addr), "R2 read header", 32'(got_hdr()), 32'(exp_hdr(0, addr)));
    chk(nwords == len + 1, "R5 word strobe count", 32'(nwords), 32'(len + 1));
    for (int k = 0; k <= len && k < nwords; k++)
      chk(words[k] == exp_mem[(addr + k) % NW], "R5 R6 read word", 32'(words[k]), 32'(exp_mem[(addr + k) % NW]));
  endtask

  task automatic do_mode(input int cmd);
    run_req(cmd, 0, 0, 0);
    chk(got_err == 0, "R11 mode done without err", 32'(got_err), 0);
    chk(lat_n == HDR, "R3 mode frame length", 32'(lat_n), 32'(HDR));
    chk(got_hdr() == exp_hdr(cmd, 0), "R3 mode header", 32'(got_hdr()), 32'(exp_hdr(cmd, 0)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!cs_o && !sk_o, "R1 lines low in reset", {30'd0, cs_o, sk_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready_o == 1, "R1 ready after reset", 32'(req_ready_o), 1);
    chk(!done_o && !rd_valid_o, "R1 no strobes after reset", {30'd0, done_o, rd_valid_o}, 0);

    // R3: disarmed write leaves memory as it was
    busy_len = 10;
    do_write(5, 16'h1234);
    do_read(5, 0);

    do_mode(2);

    // R9 R10: programming time swept across the poll limit
    for (int b = 30; b <= 50; b++) begin
      busy_len = b;
      do_write(10 + (b - 30), 16'h9000 + b * 16'h0107);
    end
    busy_len = 400;
    do_write(40, 16'hBEEF);
    chk(got_err == 1, "R10 long programming flags err", 32'(got_err), 1);
    busy_len = 5;
    do_write(NW - 1, 16'h5AA5);
    chk(got_err == 0, "R9 quick programming succeeds", 32'(got_err), 0);

    do_read(0, 0);
    do_read(8, 2);
    do_read(NW - 2, 3);
    do_read(20, 15);
    do_read(10, 15);

    do_mode(3);
    do_write(12, 16'h0F0F);
    do_read(12, 0);

    chk(rise_meas > 0 && sk_bad == 0, "R4 serial clock timing", 32'(sk_bad), 0);
    chk(gap_bad == 0, "R8 select low gap", 32'(gap_bad), 0);
    summary();
  end
endmodule